// File: doc/BRIEF.md
# Software-Armed Triggered Sample Capture Controller

This block records a burst of ADC samples into an on-chip sample memory and then plays that burst out as a byte stream. Software controls it through a small register bus. Writing the control register with its start bit set begins a capture at once. Writing the command into the upper nibble instead arms the block. The next rising edge on the external trigger pin shifts the control register right by four places, so the armed command lands on the start bit and the capture begins.

Each trigger edge consumes the pending arm. Every triggered capture therefore needs a fresh arm write first. Once the programmed number of samples has been stored, the samples go out over a valid/ready byte interface, low byte first. The start bit clears itself only after the last byte has been accepted. Until then, control writes and trigger edges have no effect, so a new capture can never overlap a transfer still in progress.

Top module: `trig_capture_ctrl`

## Requirements
- R1: The register bus decodes these byte addresses:
  - 2: control register. Reset value 0x00.
  - 4: capture length, low byte.
  - 5: capture length, high byte.
  - 6: status. Bit 0 is busy.
  - Any other address reads as 0.
  - After reset the length register reads 0x03FF, which is the full default depth.
- R2: A write to address 2 with bit 0 set, made while idle and with no start pending, makes busy read 1 two clock edges later (one edge to load the register, one to enter capture).
- R3: Bit 1 of the control register drives the `led` output only. A value with bit 0 clear never starts a capture.
- R4: While idle, each synchronised rising trigger edge replaces the control register with its value shifted right by four, with zeros entering at the top. An armed value of 0x30 thus becomes 0x03 and starts a capture.
- R5: A trigger edge while no arm is pending (bit 4 clear) starts no capture and produces no output bytes.
- R6: The trigger pin passes through a two-stage synchroniser. A pin held high for many cycles acts as exactly one edge.
- R7: A length value L captures exactly L+1 samples, taken on cycles with `adc_valid` high, so L runs from 0 to depth-1. Samples offered outside the capture phase are not stored.
- R8: Each stored 16-bit sample is sent as two bytes, low byte first, in capture order. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold steady.
- R9: `busy` stays high from the start of capture through acceptance of the last byte. When it falls, bit 0 of the control register clears and the other bits keep their values. No byte is presented while idle.
- R10: Control and length writes, and trigger edges, are ignored while busy or while a start is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from address |
| trig_in | input | 1 | Asynchronous external trigger pin |
| adc_valid | input | 1 | Sample strobe |
| adc_data | input | 16 | ADC sample word |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream byte accepted |
| out_data | output | 8 | Stream byte |
| busy | output | 1 | Capture or stream in progress |
| led | output | 1 | Follows control bit 1 |

## Verification
Starts are tried three ways: a direct start write, an arm followed by a short trigger pulse, and a trigger held high for many cycles. Comparing these separates immediate start, single shifting, and repeated shifting. Burst lengths of 1, 4, 8 and the full depth are streamed under three ready patterns: always ready, ready two cycles in three, and fully stalled. This exposes byte order, sample order, off-by-one counts and data that changes while stalled. Junk samples before and after the capture window, plus writes and trigger pulses during a stalled transfer, show whether anything leaks into memory or the control register.

// File: rtl/trigcap_pkg.sv
package trigcap_pkg;

    localparam int REG_ADDR_W = 4;

    localparam logic [REG_ADDR_W-1:0] ADDR_CTRL   = 4'h2;
    localparam logic [REG_ADDR_W-1:0] ADDR_LEN_LO = 4'h4;
    localparam logic [REG_ADDR_W-1:0] ADDR_LEN_HI = 4'h5;
    localparam logic [REG_ADDR_W-1:0] ADDR_STATUS = 4'h6;

    localparam int CMD_START_BIT = 0;
    localparam int CMD_LED_BIT   = 1;
    localparam int ARM_SHIFT     = 4;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_CAPT,
        SQ_FETCH,
        SQ_SEND
    } seq_state_e;

    // Command register: upper nibble is the arm slot, lower nibble is active.
    function automatic logic [7:0] fire_shift(input logic [7:0] cur);
        return cur >> ARM_SHIFT;
    endfunction

endpackage

// File: rtl/trigcap_sync.sv
module trigcap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            seen  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            seen  <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] & ~seen;

endmodule

// File: rtl/trigcap_regs.sv
module trigcap_regs
    import trigcap_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [7:0]            reg_wdata,
    input  logic                  trig_rise,
    input  logic                  busy,
    input  logic                  finish,
    output logic [7:0]            ctrl_q,
    output logic [AW-1:0]         len_q,
    output logic [7:0]            reg_rdata
);
    logic locked;
    logic ctrl_hit;

    assign locked   = busy | ctrl_q[CMD_START_BIT];
    assign ctrl_hit = reg_wr && (reg_addr == ADDR_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            len_q  <= '1;
        end else begin
            if (finish) begin
                ctrl_q[CMD_START_BIT] <= 1'b0;
            end else if (!locked) begin
                if (ctrl_hit) begin
                    ctrl_q <= reg_wdata;
                end else if (trig_rise) begin
                    ctrl_q <= fire_shift(ctrl_q);
                end
            end
            if (!locked && reg_wr && reg_addr == ADDR_LEN_LO) begin
                len_q[7:0] <= reg_wdata;
            end
            if (!locked && reg_wr && reg_addr == ADDR_LEN_HI) begin
                len_q[AW-1:8] <= reg_wdata[AW-9:0];
            end
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_CTRL:   reg_rdata = ctrl_q;
            ADDR_LEN_LO: reg_rdata = len_q[7:0];
            ADDR_LEN_HI: reg_rdata = 8'(len_q[AW-1:8]);
            ADDR_STATUS: reg_rdata = {7'b0, busy};
            default:     reg_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/trigcap_store.sv
module trigcap_store #(
    parameter int W     = 16,
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/trigcap_seq.sv
module trigcap_seq
    import trigcap_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int AW       = 10,
    parameter int NBYTES   = SAMPLE_W / 8,
    parameter int BSEL_W   = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW-1:0]     last_idx,
    input  logic              adc_valid,
    input  logic              out_ready,
    output logic              mem_wr_en,
    output logic [AW-1:0]     mem_addr,
    output logic              out_valid,
    output logic [BSEL_W-1:0] byte_sel,
    output logic              busy,
    output logic              finish
);
    localparam logic [BSEL_W-1:0] LAST_BYTE = BSEL_W'(NBYTES - 1);

    seq_state_e        state;
    logic [AW-1:0]     idx;
    logic [BSEL_W-1:0] bsel;
    logic              at_last;
    logic              byte_done;

    assign at_last   = (idx == last_idx);
    assign byte_done = (state == SQ_SEND) && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            idx   <= '0;
            bsel  <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        state <= SQ_CAPT;
                        idx   <= '0;
                    end
                end
                SQ_CAPT: begin
                    if (adc_valid) begin
                        if (at_last) begin
                            idx   <= '0;
                            state <= SQ_FETCH;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                SQ_FETCH: begin
                    bsel  <= '0;
                    state <= SQ_SEND;
                end
                SQ_SEND: begin
                    if (byte_done) begin
                        if (bsel == LAST_BYTE) begin
                            bsel <= '0;
                            if (at_last) begin
                                state <= SQ_IDLE;
                            end else begin
                                idx   <= idx + 1'b1;
                                state <= SQ_FETCH;
                            end
                        end else begin
                            bsel <= bsel + 1'b1;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign busy      = (state != SQ_IDLE);
    assign out_valid = (state == SQ_SEND);
    assign mem_wr_en = (state == SQ_CAPT) && adc_valid;
    assign mem_addr  = idx;
    assign byte_sel  = bsel;
    assign finish    = byte_done && (bsel == LAST_BYTE) && at_last;

endmodule

// File: rtl/trig_capture_ctrl.sv
module trig_capture_ctrl
    import trigcap_pkg::*;
#(
    parameter int SAMPLE_W    = 16,
    parameter int DEPTH       = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [7:0]            reg_wdata,
    output logic [7:0]            reg_rdata,
    input  logic                  trig_in,
    input  logic                  adc_valid,
    input  logic [SAMPLE_W-1:0]   adc_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [7:0]            out_data,
    output logic                  busy,
    output logic                  led
);
    localparam int AW     = $clog2(DEPTH);
    localparam int NBYTES = SAMPLE_W / 8;
    localparam int BSEL_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic              trig_rise;
    logic              finish;
    logic [7:0]        ctrl_q;
    logic [AW-1:0]     len_q;
    logic              mem_wr_en;
    logic [AW-1:0]     mem_addr;
    logic [SAMPLE_W-1:0] rd_data;
    logic [BSEL_W-1:0] byte_sel;

    trigcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (trig_in),
        .rise     (trig_rise)
    );

    trigcap_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .trig_rise (trig_rise),
        .busy      (busy),
        .finish    (finish),
        .ctrl_q    (ctrl_q),
        .len_q     (len_q),
        .reg_rdata (reg_rdata)
    );

    trigcap_seq #(.SAMPLE_W(SAMPLE_W), .AW(AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (ctrl_q[CMD_START_BIT]),
        .last_idx  (len_q),
        .adc_valid (adc_valid),
        .out_ready (out_ready),
        .mem_wr_en (mem_wr_en),
        .mem_addr  (mem_addr),
        .out_valid (out_valid),
        .byte_sel  (byte_sel),
        .busy      (busy),
        .finish    (finish)
    );

    trigcap_store #(.W(SAMPLE_W), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .wr_en   (mem_wr_en),
        .wr_addr (mem_addr),
        .wr_data (adc_data),
        .rd_addr (mem_addr),
        .rd_data (rd_data)
    );

    assign out_data = rd_data[int'(byte_sel) * 8 +: 8];
    assign led      = ctrl_q[CMD_LED_BIT];

endmodule

// File: rtl/trigcap_chk.sv
module trigcap_chk
    import trigcap_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  reg_wr,
    input logic [REG_ADDR_W-1:0] reg_addr,
    input logic                  wr_start,
    input logic                  busy,
    input logic                  out_valid,
    input logic                  out_ready,
    input logic [7:0]            out_data,
    input logic [7:0]            ctrl_q,
    input logic                  trig_rise,
    input logic                  finish
);
    logic ctrl_wr;
    assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);

    AST_START_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (!busy && !ctrl_q[0] && ctrl_wr && wr_start) |=> ##1 busy); // R2
    AST_NO_START_BIT: assert property (@(posedge clk) disable iff (rst)
        (!busy && !ctrl_q[0] && ctrl_wr && !wr_start) |=> ##1 !busy); // R3
    AST_TRIG_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (!busy && !ctrl_q[0] && trig_rise && !ctrl_wr) |=> (ctrl_q == ($past(ctrl_q) >> 4))); // R4
    AST_SINGLE_EDGE: assert property (@(posedge clk) disable iff (rst)
        trig_rise |=> !trig_rise); // R6
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !out_valid); // R9
    AST_FINISH_CLEAR: assert property (@(posedge clk) disable iff (rst)
        finish |=> (!busy && !ctrl_q[0])); // R9
    AST_LOCKED_CTRL: assert property (@(posedge clk) disable iff (rst)
        (busy && !finish) |=> $stable(ctrl_q)); // R10

endmodule

bind trig_capture_ctrl trigcap_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .wr_start  (reg_wdata[0]),
    .busy      (busy),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .ctrl_q    (ctrl_q),
    .trig_rise (trig_rise),
    .finish    (finish)
);

// File: tb/tb_trig_capture_ctrl.sv
module tb_trig_capture_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        trig_in = 1'b0;
    logic        adc_valid = 1'b0;
    logic [15:0] adc_data = 16'h0;
    logic        out_valid;
    logic        out_ready;
    logic [7:0]  out_data;
    logic        busy;
    logic        led;

    int          checks = 0;
    int          errors = 0;
    int          bytes_seen = 0;
    int          stall_mode = 0;
    int          cyc = 0;
    bit          done = 1'b0;
    logic [7:0]  exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_capture_ctrl dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_in(trig_in),
        .adc_valid(adc_valid), .adc_data(adc_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .busy(busy), .led(led)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Reference byte stream: each sample offered during capture pushes lo, hi.
    always @(negedge clk) begin
        cyc++;
        case (stall_mode)
            0: out_ready = 1'b1;
            1: out_ready = (cyc % 3) != 0;
            default: out_ready = 1'b0;
        endcase
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9", "byte with none expected", out_data, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(out_data == e, "R8", "stream byte", out_data, e);
            end
            bytes_seen++;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_trig(input int hold);
        @(negedge clk);
        trig_in = 1'b1;
        repeat (hold) @(negedge clk);
        trig_in = 1'b0;
    endtask

    task automatic capture(input int n, input int seed, input bit gaps);
        int t = 0;
        while (!busy && t < 20) begin
            @(negedge clk);
            t++;
        end
        chk(busy, "R2", "busy at capture start", busy, 1);
        bytes_seen = 0;
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 3 == 1)) begin
                adc_valid = 1'b0;
                @(negedge clk);
            end
            adc_valid = 1'b1;
            adc_data = 16'(i * 37 + seed * 4099 + 5);
            exp_q.push_back(adc_data[7:0]);
            exp_q.push_back(adc_data[15:8]);
            @(negedge clk);
        end
        for (int j = 0; j < 3; j++) begin
            adc_valid = 1'b1;
            adc_data = 16'hDEAD ^ 16'(j);
            @(negedge clk);
        end
        adc_valid = 1'b0;
    endtask

    task automatic complete(input int n);
        int t = 0;
        while (busy && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(!busy, "R9", "busy cleared after stream", busy, 0);
        chk(exp_q.size() == 0, "R7", "bytes left unsent", exp_q.size(), 0);
        chk(bytes_seen == 2 * n, "R7", "byte count", bytes_seen, 2 * n);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state (R1)
        rd(4'h2, v); chk(v == 8'h00, "R1", "ctrl reset", v, 8'h00);
        rd(4'h4, v); chk(v == 8'hFF, "R1", "len lo reset", v, 8'hFF);
        rd(4'h5, v); chk(v == 8'h03, "R1", "len hi reset", v, 8'h03);
        rd(4'h6, v); chk(v == 8'h00, "R1", "status reset", v, 8'h00);
        rd(4'h9, v); chk(v == 8'h00, "R1", "unmapped read", v, 8'h00);
        chk(!out_valid && !led, "R1", "outputs at reset", {out_valid, led}, 0);

        // Direct start, 4 samples, junk samples before start (R2, R7)
        stall_mode = 1;
        wr(4'h4, 8'h03); wr(4'h5, 8'h00);
        rd(4'h4, v); chk(v == 8'h03, "R1", "len lo readback", v, 8'h03);
        adc_valid = 1'b1; adc_data = 16'hBEEF;
        repeat (3) @(negedge clk);
        adc_valid = 1'b0;
        wr(4'h2, 8'h03);
        chk(!busy, "R2", "busy one edge after write", busy, 0);
        @(negedge clk);
        chk(busy, "R2", "busy two edges after write", busy, 1);
        chk(led, "R3", "led follows bit1", led, 1);
        capture(4, 1, 1'b1);
        complete(4);
        rd(4'h2, v); chk(v == 8'h02, "R9", "start bit cleared, led bit kept", v, 8'h02);

        // Trigger with no arm pending (R5), led-only write (R3)
        pulse_trig(3);
        repeat (6) @(negedge clk);
        rd(4'h2, v); chk(v == 8'h00, "R4", "shift of 0x02", v, 8'h00);
        chk(!busy, "R5", "no capture from unarmed edge", busy, 0);
        chk(!led, "R3", "led off", led, 0);
        wr(4'h2, 8'h02);
        repeat (5) @(negedge clk);
        chk(!busy, "R3", "bit1 only starts nothing", busy, 0);
        chk(led, "R3", "led on", led, 1);
        wr(4'h2, 8'h00);

        // Arm then trigger, stalled stream used to probe locking (R4, R10)
        wr(4'h4, 8'h07);
        stall_mode = 2;
        wr(4'h2, 8'h30);
        repeat (5) @(negedge clk);
        rd(4'h2, v); chk(v == 8'h30, "R4", "armed value waits", v, 8'h30);
        chk(!busy, "R4", "armed not busy", busy, 0);
        pulse_trig(3);
        capture(8, 2, 1'b0);
        rd(4'h2, v); chk(v == 8'h03, "R4", "armed value shifted", v, 8'h03);
        chk(out_valid && busy, "R8", "held byte under stall", out_valid, 1);
        wr(4'h2, 8'h30);
        wr(4'h4, 8'h01);
        rd(4'h2, v); chk(v == 8'h03, "R10", "ctrl write ignored while busy", v, 8'h03);
        rd(4'h4, v); chk(v == 8'h07, "R10", "len write ignored while busy", v, 8'h07);
        pulse_trig(3);
        repeat (5) @(negedge clk);
        rd(4'h2, v); chk(v == 8'h03, "R10", "trigger ignored while busy", v, 8'h03);
        stall_mode = 1;
        complete(8);
        rd(4'h2, v); chk(v == 8'h02, "R9", "start cleared after trigger run", v, 8'h02);

        // Trigger held high acts once (R6)
        wr(4'h2, 8'hA0);
        trig_in = 1'b1;
        repeat (12) @(negedge clk);
        rd(4'h2, v); chk(v == 8'h0A, "R6", "held trigger single shift", v, 8'h0A);
        chk(!busy, "R5", "bit4 clear starts nothing", busy, 0);
        trig_in = 1'b0;
        repeat (3) @(negedge clk);
        pulse_trig(3);
        repeat (6) @(negedge clk);
        rd(4'h2, v); chk(v == 8'h00, "R4", "zero fill on second shift", v, 8'h00);

        // Shortest capture (R7)
        stall_mode = 0;
        wr(4'h4, 8'h00); wr(4'h5, 8'h00);
        wr(4'h2, 8'h01);
        capture(1, 3, 1'b0);
        complete(1);
        rd(4'h2, v); chk(v == 8'h00, "R9", "ctrl after single sample", v, 8'h00);

        // Full depth via arm (R7)
        wr(4'h4, 8'hFF); wr(4'h5, 8'h03);
        wr(4'h2, 8'h10);
        pulse_trig(2);
        capture(1024, 4, 1'b1);
        complete(1024);
        rd(4'h6, v); chk(v == 8'h00, "R1", "status idle at end", v, 8'h00);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule